// File: doc/BRIEF.md
# LIN Transceiver Mode Controller

This block is the digital mode controller for a single-wire LIN physical-layer interface. It keeps track of three operating modes: battery standby, normal and sleep. It decides when the external voltage regulator is switched on. It gates the bus driver so that transmit data reaches the bus only in normal mode, and it filters the bus comparator before the level reaches the receive line. Every time window is a count of clock ticks set by a parameter.

After reset the controller is in standby and asks for the regulator to be on. The host moves it to normal by raising the enable pin while the supply-good flag is present. The host puts it to sleep by holding enable low while in normal mode. In sleep the regulator request is withdrawn. A dominant bus level that lasts long enough wakes the controller. After a wake-up the controller returns to standby and holds the receive line low as an interrupt until the host brings it back to normal. If the supply stayed up during sleep, raising enable takes the controller straight back to normal.

The enable pin and the bus comparator each pass through a two-flop synchroniser. The synchronised enable is debounced over `EN_DEB_TICKS`. The synchronised bus level is debounced over `RX_DEB_TICKS` for the receive path, and its dominant time is counted against `WAKE_TICKS` for wake-up detection.

Top module: `lin_xcvr_ctrl`

## Requirements
- R1: After reset the controller is in standby: `inh_on`=1, `rxd`=1 and `drv_dom`=0.
- R2: From standby, `en_async` held high for `EN_DEB_TICKS` cycles with `vcc_ok`=1 enters normal mode at the 3+`EN_DEB_TICKS`-th rising edge after the change. A high pulse shorter than `EN_DEB_TICKS` cycles leaves the controller in standby.
- R3: In normal mode `drv_dom` is the inverse of `txd`, where `drv_dom`=1 pulls the bus dominant. `rxd` follows the debounced bus level, where `bus_rx`=0 is dominant and gives `rxd`=0. A bus change held for `RX_DEB_TICKS` cycles reaches `rxd` at the 2+`RX_DEB_TICKS`-th rising edge.
- R4: In normal mode, `vcc_ok`=0 returns the controller to standby at the next rising edge, with `inh_on`=1.
- R5: Sleep is entered only from normal mode. `en_async` held low for `EN_DEB_TICKS` cycles enters sleep at the 3+`EN_DEB_TICKS`-th edge and drives `inh_on` to 0. A low enable in standby never leads to sleep.
- R6: In normal mode, a low pulse on `en_async` shorter than `EN_DEB_TICKS` cycles leaves the mode unchanged.
- R7: In sleep, `bus_rx`=0 held for `WAKE_TICKS` cycles moves the controller to standby at the 2+`WAKE_TICKS`-th edge and sets `inh_on`=1. Shorter dominant pulses leave it in sleep. The controller stays in sleep whatever `vcc_ok` does.
- R8: After an accepted wake-up, `rxd` is held at 0 until normal mode is entered. From then on `rxd` again follows the bus.
- R9: In sleep with `vcc_ok`=1, `en_async` held high for `EN_DEB_TICKS` cycles enters normal mode directly at the 3+`EN_DEB_TICKS`-th edge.
- R10: In normal mode, a bus level change lasting fewer than `RX_DEB_TICKS` cycles does not change `rxd`.
- R11: Outside normal mode `drv_dom` is 0 whatever `txd` is.
- R12: The wake-up count restarts whenever the bus is recessive. Two dominant pulses, each shorter than `WAKE_TICKS` cycles and separated by one recessive cycle, do not wake the controller.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; all windows count its ticks |
| rst_n | input | 1 | Synchronous active-low reset |
| en_async | input | 1 | Enable pin from the host, asynchronous |
| vcc_ok | input | 1 | Logic supply present and above its undervoltage level |
| txd | input | 1 | Transmit data, 0 = dominant |
| bus_rx | input | 1 | Bus comparator output, asynchronous, 0 = dominant |
| inh_on | output | 1 | Regulator-on request, 0 in sleep |
| rxd | output | 1 | Receive data, or the active-low wake-up interrupt |
| drv_dom | output | 1 | Bus driver pull-down, 1 = drive dominant |

## Verification
A change on an asynchronous input reaches a debounced signal two synchroniser edges plus one window later. A mode decision based on enable therefore lands at edge 3+`EN_DEB_TICKS`, an `rxd` change at edge 2+`RX_DEB_TICKS`, and a wake-up at edge 2+`WAKE_TICKS`. A change on `vcc_ok` acts at the very next edge, and `txd` reaches `drv_dom` within the same cycle. The bench drives every input on a falling edge and counts rising edges from there. It samples once on the falling edge just before the edge where an output is due and once just after it, so that a result arriving one cycle early or one cycle late is caught. The bench runs with short windows so that every boundary case can be reached within a few hundred cycles.

// File: rtl/lin_xcvr_pkg.sv
// Shared types for the LIN transceiver mode controller.
package lin_xcvr_pkg;

    // Operating modes of the controller.
    typedef enum logic [1:0] {
        MODE_STANDBY = 2'd0,
        MODE_NORMAL  = 2'd1,
        MODE_SLEEP   = 2'd2
    } lin_mode_e;

endpackage

// File: rtl/lin_sync2.sv
// Two-flop synchroniser for a bundle of asynchronous single-bit inputs.
// Assumes each bit is independent (no multi-bit coherence is needed).
// Reset loads RST_VAL into both stages so the outputs have a defined idle level.
module lin_sync2 #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Two-stage capture of the asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= RST_VAL;
            stage2_q <= RST_VAL;
        end else begin
            stage1_q <= d_i;
            stage2_q <= stage1_q;
        end
    end

    assign q_o = stage2_q;

endmodule

// File: rtl/lin_debounce.sv
// Symmetric debounce filter. The output takes the input value once the input
// has differed from the output for TICKS consecutive cycles; any shorter
// excursion is discarded. Assumes a synchronous input and TICKS >= 1.
module lin_debounce #(
    parameter int   TICKS   = 250,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    localparam int             CW   = $clog2(TICKS + 1);
    localparam logic [CW-1:0]  LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt_q;
    logic          out_q;

    // Count cycles of disagreement; commit the new level on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            out_q <= RST_VAL;
        end else if (d_i == out_q) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
            out_q <= d_i;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign q_o = out_q;

    // Short excursions never move the output (serves R10 on the bus, R6 on enable).
    p_glitch_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (d_i == out_q || cnt_q != LAST) |=> $stable(out_q));

endmodule

// File: rtl/lin_wake_filter.sv
// Wake-up filter. While armed (sleep mode), counts consecutive dominant
// cycles and flags a wake-up once TICKS of them have been seen. A single
// recessive cycle, or disarming, clears the count. Assumes TICKS >= 2.
module lin_wake_filter #(
    parameter int TICKS = 6250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic bus_dom_i,
    output logic wake_o
);

    localparam int            CW   = $clog2(TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] dom_cnt_q;

    // Dominant-time counter, restarted by recessive bus or by disarm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dom_cnt_q <= '0;
        end else if (!arm_i || !bus_dom_i) begin
            dom_cnt_q <= '0;
        end else if (dom_cnt_q != LAST) begin
            dom_cnt_q <= dom_cnt_q + 1'b1;
        end
    end

    assign wake_o = arm_i && bus_dom_i && (dom_cnt_q == LAST);

    // A wake-up follows a cycle that was itself dominant and armed.
    p_wake_needs_dom_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> ($past(bus_dom_i) && $past(arm_i)));

    // A recessive cycle forbids a wake-up on the cycle after it.
    p_restart_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_i && !bus_dom_i) |=> !wake_o);

endmodule

// File: rtl/lin_mode_fsm.sv
// Mode state machine for the LIN transceiver controller.
// Inputs are already synchronised and debounced. The supply flag is assumed
// synchronous to clk. A wake-up takes priority over enable in sleep.
module lin_mode_fsm
    import lin_xcvr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en_i,
    input  logic      vcc_ok_i,
    input  logic      wake_i,
    output lin_mode_e mode_o,
    output logic      wake_flag_o
);

    lin_mode_e mode_q;
    lin_mode_e mode_d;
    logic      wake_flag_q;
    logic      wake_flag_d;

    // Next-mode and interrupt-flag decision.
    always_comb begin
        mode_d      = mode_q;
        wake_flag_d = wake_flag_q;
        unique case (mode_q)
            MODE_STANDBY: begin
                if (vcc_ok_i && en_i) begin
                    mode_d      = MODE_NORMAL;
                    wake_flag_d = 1'b0;
                end
            end
            MODE_NORMAL: begin
                if (!vcc_ok_i) begin
                    mode_d = MODE_STANDBY;
                end else if (!en_i) begin
                    mode_d = MODE_SLEEP;
                end
            end
            MODE_SLEEP: begin
                if (wake_i) begin
                    mode_d      = MODE_STANDBY;
                    wake_flag_d = 1'b1;
                end else if (vcc_ok_i && en_i) begin
                    mode_d      = MODE_NORMAL;
                    wake_flag_d = 1'b0;
                end
            end
            default: begin
                mode_d = MODE_STANDBY;
            end
        endcase
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q      <= MODE_STANDBY;
            wake_flag_q <= 1'b0;
        end else begin
            mode_q      <= mode_d;
            wake_flag_q <= wake_flag_d;
        end
    end

    assign mode_o      = mode_q;
    assign wake_flag_o = wake_flag_q;

    // Normal mode is entered only with enable and supply both present.
    p_normal_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_q == MODE_NORMAL) |-> $past(en_i && vcc_ok_i));

    // Supply loss in normal mode falls back to standby.
    p_vcc_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_NORMAL && !vcc_ok_i) |=> (mode_q == MODE_STANDBY));

    // Sleep is reached only from normal mode.
    p_sleep_from_normal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_q == MODE_SLEEP) |-> ($past(mode_q) == MODE_NORMAL));

    // An accepted wake-up lands in standby with the interrupt flag set.
    p_wake_to_standby_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_SLEEP && wake_i) |=> (mode_q == MODE_STANDBY && wake_flag_q));

    // The interrupt flag never survives into normal mode.
    p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_NORMAL) |-> !wake_flag_q);

endmodule

// File: rtl/lin_xcvr_ctrl.sv
// Top of the LIN transceiver mode controller. Synchronises the enable pin
// and the bus comparator, debounces enable and the received level, filters
// wake-up events, and drives the regulator request, receive line and driver.
// Assumes vcc_ok is already synchronous to clk.
module lin_xcvr_ctrl
    import lin_xcvr_pkg::*;
#(
    parameter int EN_DEB_TICKS = 3125,
    parameter int RX_DEB_TICKS = 250,
    parameter int WAKE_TICKS   = 6250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_async,
    input  logic vcc_ok,
    input  logic txd,
    input  logic bus_rx,
    output logic inh_on,
    output logic rxd,
    output logic drv_dom
);

    localparam int SYNC_W = 2;

    logic [SYNC_W-1:0] raw_in;
    logic [SYNC_W-1:0] sync_out;
    logic              en_s;
    logic              bus_s;
    logic              en_f;
    logic              rx_f;
    logic              wake;
    logic              wake_flag;
    lin_mode_e         mode;

    assign raw_in = {bus_rx, en_async};
    assign en_s   = sync_out[0];
    assign bus_s  = sync_out[1];

    lin_sync2 #(
        .W       (SYNC_W),
        .RST_VAL (2'b10)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (sync_out)
    );

    lin_debounce #(
        .TICKS   (EN_DEB_TICKS),
        .RST_VAL (1'b0)
    ) u_en_deb (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (en_s),
        .q_o   (en_f)
    );

    lin_debounce #(
        .TICKS   (RX_DEB_TICKS),
        .RST_VAL (1'b1)
    ) u_rx_deb (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (bus_s),
        .q_o   (rx_f)
    );

    lin_wake_filter #(
        .TICKS (WAKE_TICKS)
    ) u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_i     (mode == MODE_SLEEP),
        .bus_dom_i (!bus_s),
        .wake_o    (wake)
    );

    lin_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en_f),
        .vcc_ok_i    (vcc_ok),
        .wake_i      (wake),
        .mode_o      (mode),
        .wake_flag_o (wake_flag)
    );

    // Output decode: regulator request, receive line/interrupt, driver gate.
    always_comb begin
        inh_on  = (mode != MODE_SLEEP);
        drv_dom = (mode == MODE_NORMAL) && !txd;
        rxd     = (mode == MODE_NORMAL) ? rx_f : !wake_flag;
    end

    // A debounced bus change appears on rxd in normal mode without delay.
    p_rx_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_NORMAL && $past(mode) == MODE_NORMAL && $changed(rx_f)) |-> (rxd == rx_f));

endmodule

// File: tb/lin_xcvr_ctrl_bench.sv
// Directed bench for the LIN transceiver mode controller.
module lin_xcvr_ctrl_bench;

    localparam int EN  = 20;
    localparam int RX  = 8;
    localparam int WK  = 40;

    logic clk = 1'b0;
    logic rst_n, en_async, vcc_ok, txd, bus_rx;
    logic inh_on, rxd, drv_dom;
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;

    always #4 clk = ~clk;

    lin_xcvr_ctrl #(
        .EN_DEB_TICKS (EN),
        .RX_DEB_TICKS (RX),
        .WAKE_TICKS   (WK)
    ) u_lin_xcvr_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_async (en_async),
        .vcc_ok   (vcc_ok),
        .txd      (txd),
        .bus_rx   (bus_rx),
        .inh_on   (inh_on),
        .rxd      (rxd),
        .drv_dom  (drv_dom)
    );

    task automatic chk(input string tag, input logic got, input logic exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    // Advance k rising edges, then stop on the following falling edge.
    task automatic edges(input int k);
        repeat (k) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; en_async = 1'b0; vcc_ok = 1'b1; txd = 1'b1; bus_rx = 1'b1;
        edges(4);
        rst_n = 1'b1;
        edges(1);
        chk("R1 inh_on after reset", inh_on, 1'b1);
        chk("R1 rxd after reset", rxd, 1'b1);
        chk("R1 drv_dom after reset", drv_dom, 1'b0);
    endtask

    task automatic t_enable_filter;
        txd = 1'b0;
        en_async = 1'b1;
        edges(EN - 1);
        en_async = 1'b0;
        edges(EN + 5);
        chk("R2 short enable pulse ignored", drv_dom, 1'b0);
        chk("R11 txd low outside normal", drv_dom, 1'b0);
        en_async = 1'b1;
        edges(2 + EN);
        chk("R2 still standby one edge early", drv_dom, 1'b0);
        edges(1);
        chk("R2 normal at edge 3+EN", drv_dom, 1'b1);
    endtask

    task automatic t_normal_io;
        txd = 1'b1;
        edges(0);
        chk("R3 txd high gives recessive", drv_dom, 1'b0);
        txd = 1'b0;
        edges(0);
        chk("R3 txd low gives dominant", drv_dom, 1'b1);
        bus_rx = 1'b0;
        edges(RX + 1);
        chk("R3 rxd unchanged one edge early", rxd, 1'b1);
        edges(1);
        chk("R3 rxd low at edge 2+RX", rxd, 1'b0);
        bus_rx = 1'b1;
        edges(RX + 2);
        chk("R3 rxd back high", rxd, 1'b1);
    endtask

    task automatic t_rx_glitch;
        bus_rx = 1'b0;
        edges(RX - 1);
        chk("R10 rxd high during glitch", rxd, 1'b1);
        bus_rx = 1'b1;
        edges(RX + 5);
        chk("R10 short bus glitch ignored", rxd, 1'b1);
    endtask

    task automatic t_en_glitch;
        en_async = 1'b0;
        edges(EN - 1);
        en_async = 1'b1;
        edges(EN + 5);
        chk("R6 short low enable keeps inh", inh_on, 1'b1);
        chk("R6 short low enable keeps normal", drv_dom, 1'b1);
    endtask

    task automatic t_enter_sleep;
        en_async = 1'b0;
        edges(2 + EN);
        chk("R5 not yet asleep", inh_on, 1'b1);
        edges(1);
        chk("R5 inh off in sleep", inh_on, 1'b0);
        chk("R11 driver off in sleep", drv_dom, 1'b0);
        chk("R5 rxd high in sleep", rxd, 1'b1);
    endtask

    task automatic t_wake_reject;
        vcc_ok = 1'b0;
        edges(3);
        chk("R7 sleep holds without supply", inh_on, 1'b0);
        bus_rx = 1'b0;
        edges(WK - 1);
        bus_rx = 1'b1;
        edges(1);
        bus_rx = 1'b0;
        edges(WK - 1);
        bus_rx = 1'b1;
        edges(WK + 5);
        chk("R12 split dominant does not wake", inh_on, 1'b0);
        chk("R7 short dominant ignored", rxd, 1'b1);
    endtask

    task automatic t_wake_accept;
        bus_rx = 1'b0;
        edges(WK + 1);
        chk("R7 still asleep one edge early", inh_on, 1'b0);
        edges(1);
        chk("R7 wake reasserts inh", inh_on, 1'b1);
        chk("R8 interrupt low after wake", rxd, 1'b0);
        chk("R11 driver off in standby", drv_dom, 1'b0);
        bus_rx = 1'b1;
        edges(RX + 10);
        chk("R8 interrupt held with recessive bus", rxd, 1'b0);
        vcc_ok = 1'b1;
        en_async = 1'b1;
        edges(2 + EN);
        chk("R8 interrupt held until normal", rxd, 1'b0);
        edges(1);
        chk("R8 rxd follows bus in normal", rxd, 1'b1);
        chk("R2 normal after wake", drv_dom, 1'b1);
    endtask

    task automatic t_vcc_loss;
        vcc_ok = 1'b0;
        edges(1);
        chk("R4 supply loss leaves normal", drv_dom, 1'b0);
        chk("R4 inh stays on", inh_on, 1'b1);
        vcc_ok = 1'b1;
        edges(1);
        chk("R2 supply back returns to normal", drv_dom, 1'b1);
    endtask

    task automatic t_sleep_direct;
        en_async = 1'b0;
        edges(3 + EN);
        chk("R5 asleep again", inh_on, 1'b0);
        en_async = 1'b1;
        edges(2 + EN);
        chk("R9 still asleep one edge early", inh_on, 1'b0);
        edges(1);
        chk("R9 direct wake to normal inh", inh_on, 1'b1);
        chk("R9 direct wake to normal drive", drv_dom, 1'b1);
        chk("R9 no interrupt on direct path", rxd, 1'b1);
    endtask

    task automatic t_no_sleep_from_standby;
        vcc_ok = 1'b0;
        edges(1);
        en_async = 1'b0;
        edges(EN + 5);
        chk("R5 low enable in standby keeps inh", inh_on, 1'b1);
        vcc_ok = 1'b1;
        edges(2);
        chk("R5 standby not sleep", inh_on, 1'b1);
        chk("R11 driver off in standby", drv_dom, 1'b0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_enable_filter();
        t_normal_io();
        t_rx_glitch();
        t_en_glitch();
        t_enter_sleep();
        t_wake_reject();
        t_wake_accept();
        t_vcc_loss();
        t_sleep_direct();
        t_no_sleep_from_standby();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule